// File: doc/BRIEF.md
# Truncating Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a signed 32-bit integer, always discarding the fraction (truncation toward zero). The operand arrives already split into a class code, a sign, a signed unbiased exponent and a mantissa that carries its leading one explicitly. The block returns the integer together with two flags: one saying that fraction bits were thrown away, and one saying that the operand could not be represented (out of range, infinite or not a number).

Results that do not fit saturate by sign, so the most negative integer is a legal exact result while its positive counterpart is an overflow. Whenever the invalid flag is raised, the inexact flag is forced low. The block never reports underflow. It holds one register stage: an operand presented with `inValid` high is answered one clock later with `outValid` high.

Top module: `fp2int_trunc`

## Requirements
- R1: An operand of class code 0 (zero) gives result 0 with both flags low, whatever its sign.
- R2: A class 1 (number) operand whose exponent, read as a 10-bit two's complement value, is 32 or more gives the saturated result (0x7FFFFFFF for sign 0, 0x80000000 for sign 1) with the invalid flag set.
- R3: For a class 1 operand with exponent below 32 the value is mantissa × 2^(exponent−31); the result magnitude is the integer part of that value and the result is its two's complement when the sign is 1.
- R4: The inexact flag is set exactly when a non-overflowing class 1 conversion discards a nonzero fraction bit, including every exponent below zero (result 0, inexact when the mantissa is nonzero); the magnitude is never incremented.
- R5: A magnitude above 0x80000000, or equal to 0x80000000 with sign 0, is an overflow and saturates as in R2; a magnitude of 0x80000000 with sign 1 yields 0x80000000 with both flags low.
- R6: Class codes 2 (infinity), 3 (quiet NaN), 4 (signalling NaN) and the unused codes 5 to 7 give the saturated result by sign with the invalid flag set.
- R7: The inexact and invalid flags are never both set; on any saturation the inexact flag is low.
- R8: `outValid` is high exactly one clock after an accepted `inValid`; result and flags change only on an accepted operand and otherwise hold; after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| inClass | input | 3 | Class code (0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN) |
| inSign | input | 1 | Operand sign, 1 is negative |
| inExp | input | 10 | Unbiased exponent, two's complement |
| inMant | input | 32 | Mantissa, leading one at bit 31 |
| outValid | output | 1 | Result present this cycle |
| outResult | output | 32 | Signed integer result |
| outInexact | output | 1 | Fraction bits were discarded |
| outInvalid | output | 1 | Operand not representable; result saturated |

## Verification
Every result, both flags and `outValid` are due at the first rising edge after the operand is presented, so they are visible one full clock after the stimulus. The bench drives each operand on a falling edge and compares all outputs on the next falling edge against a behavioural model fed from a queue, so each comparison sits half a clock clear of the updating edge. Idle cycles are compared too, which shows that `outValid` drops and the held result does not move.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new result
    logic forceZero; // zero class
    logic forceSat;  // special class or exponent too large
    logic useShift;  // finite number in shifting range
    logic belowOne;  // negative exponent: integer part is zero
  } ctrlStrobe_t;

endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       inClass,
  input  logic [EXP_W-1:0] inExp,
  output ctrlStrobe_t      strobe,
  output logic             outValid
);

  localparam logic signed [EXP_W-1:0] EXP_LIMIT = EXP_W'(DATA_W);

  logic isNum;
  logic isZero;
  logic expTooBig;
  logic expNeg;

  always_comb begin
    isZero    = (inClass == CLS_ZERO);
    isNum     = (inClass == CLS_NUM);
    expTooBig = ($signed(inExp) >= EXP_LIMIT);
    expNeg    = inExp[EXP_W-1];

    strobe.load      = inValid;
    strobe.forceZero = isZero;
    strobe.forceSat  = (!isZero && !isNum) || (isNum && expTooBig);
    strobe.useShift  = isNum && !expTooBig;
    strobe.belowOne  = isNum && expNeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [DATA_W-1:0] inMant,
  output logic [DATA_W-1:0] outResult,
  output logic              outInexact,
  output logic              outInvalid
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] MIN_MAG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_SAT = {1'b0, {(DATA_W-1){1'b1}}};

  logic [SH_W-1:0]     shiftAmt;
  logic [2*DATA_W-1:0] wide;
  logic [DATA_W-1:0]   mag;
  logic                sticky;
  logic                magTooBig;
  logic                saturate;
  logic [DATA_W-1:0]   nextResult;
  logic                nextInexact;

  always_comb begin
    // exponent in 0..DATA_W-1 here, so shift = DATA_W-1-exp
    shiftAmt = SH_W'(DATA_W - 1) - inExp[SH_W-1:0];
    wide     = {inMant, {DATA_W{1'b0}}} >> shiftAmt;
    if (strobe.belowOne) begin
      mag    = '0;
      sticky = |inMant;
    end else begin
      mag    = wide[2*DATA_W-1:DATA_W];
      sticky = |wide[DATA_W-1:0];
    end

    magTooBig = (mag > MIN_MAG) || ((mag == MIN_MAG) && !inSign);
    saturate  = strobe.forceSat || (strobe.useShift && magTooBig);

    if (strobe.forceZero)  nextResult = '0;
    else if (saturate)     nextResult = inSign ? MIN_MAG : POS_SAT;
    else if (inSign)       nextResult = -mag;
    else                   nextResult = mag;

    nextInexact = strobe.useShift && !saturate && sticky;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outResult  <= '0;
      outInexact <= 1'b0;
      outInvalid <= 1'b0;
    end else if (strobe.load) begin
      outResult  <= nextResult;
      outInexact <= nextInexact;
      outInvalid <= saturate && !strobe.forceZero;
    end
  end

endmodule

// File: rtl/fp2int_trunc.sv
module fp2int_trunc
  import f2i_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        inClass,
  input  logic              inSign,
  input  logic [EXP_W-1:0]  inExp,
  input  logic [DATA_W-1:0] inMant,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic              outInexact,
  output logic              outInvalid
);

  ctrlStrobe_t strobe;

  f2i_ctrl #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inClass  (inClass),
    .inExp    (inExp),
    .strobe   (strobe),
    .outValid (outValid)
  );

  f2i_datapath #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inSign     (inSign),
    .inExp      (inExp),
    .inMant     (inMant),
    .outResult  (outResult),
    .outInexact (outInexact),
    .outInvalid (outInvalid)
  );

endmodule

// File: rtl/fp2int_trunc_chk.sv
module fp2int_trunc_chk #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        inClass,
  input logic              inSign,
  input logic [EXP_W-1:0]  inExp,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult,
  input logic              outInexact,
  input logic              outInvalid
);

  localparam logic [DATA_W-1:0] NEG_SAT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_SAT = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [EXP_W-1:0] EXP_LIMIT = EXP_W'(DATA_W);

  // R1
  p_zero_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass == 3'd0 |=> outResult == '0 && !outInexact && !outInvalid);

  // R2
  p_big_exp_sat_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass == 3'd1 && $signed(inExp) >= EXP_LIMIT
    |=> outInvalid && outResult == ($past(inSign) ? NEG_SAT : POS_SAT));

  // R6
  p_special_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inClass >= 3'd2
    |=> outInvalid && !outInexact && outResult == ($past(inSign) ? NEG_SAT : POS_SAT));

  // R7
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outInexact && outInvalid));

  // R8
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid && $stable(outResult) && $stable(outInvalid));

endmodule

bind fp2int_trunc fp2int_trunc_chk #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inClass    (inClass),
  .inSign     (inSign),
  .inExp      (inExp),
  .outValid   (outValid),
  .outResult  (outResult),
  .outInexact (outInexact),
  .outInvalid (outInvalid)
);

// File: tb/fp2int_trunc_tb.sv
module fp2int_trunc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inClass = 3'd0;
  logic        inSign = 1'b0;
  logic [9:0]  inExp = '0;
  logic [31:0] inMant = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic        outInexact;
  logic        outInvalid;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        v;
    logic [31:0] r;
    logic        nx;
    logic        nv;
    string       tag;
  } expect_t;

  expect_t expQ[$];
  expect_t held;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2int_trunc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass),
    .inSign(inSign), .inExp(inExp), .inMant(inMant),
    .outValid(outValid), .outResult(outResult),
    .outInexact(outInexact), .outInvalid(outInvalid)
  );

  // behavioural model of the integer conversion
  function automatic expect_t model(int cls, bit sgn, int e, longint unsigned m, string tag);
    expect_t x;
    longint unsigned mag;
    longint signed   val;
    bit frac;
    x.v = 1'b1; x.tag = tag; x.nx = 1'b0; x.nv = 1'b0;
    if (cls == 0) begin
      x.r = 32'd0;
      return x;
    end
    if (cls != 1 || e >= 32) begin
      x.nv = 1'b1;
      x.r  = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return x;
    end
    if (e < 0) begin
      mag  = 0;
      frac = (m != 0);
    end else begin
      mag  = m / (64'd1 << (31 - e));
      frac = (m % (64'd1 << (31 - e))) != 0;
    end
    if (mag > 64'h8000_0000 || (mag == 64'h8000_0000 && !sgn)) begin
      x.nv = 1'b1;
      x.r  = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return x;
    end
    val  = sgn ? -longint'(mag) : longint'(mag);
    x.r  = val[31:0];
    x.nx = frac;
    return x;
  endfunction

  task automatic compareNow();
    expect_t e;
    e = expQ.pop_front();
    checks++;
    if (e.v) begin
      if (!outValid || outResult !== e.r || outInexact !== e.nx || outInvalid !== e.nv) begin
        fails++;
        $display("FAIL %s: got v=%0b r=%h nx=%0b nv=%0b, expected v=1 r=%h nx=%0b nv=%0b",
                 e.tag, outValid, outResult, outInexact, outInvalid, e.r, e.nx, e.nv);
      end
      held = e;
    end else begin
      // idle: valid low, previous result held (R8)
      if (outValid !== 1'b0 || outResult !== held.r || outInexact !== held.nx || outInvalid !== held.nv) begin
        fails++;
        $display("FAIL R8 idle hold: got v=%0b r=%h nx=%0b nv=%0b, expected v=0 r=%h nx=%0b nv=%0b",
                 outValid, outResult, outInexact, outInvalid, held.r, held.nx, held.nv);
      end
    end
  endtask

  task automatic apply(int cls, bit sgn, int e, longint unsigned m, string tag);
    @(negedge clk);
    inValid = 1'b1; inClass = cls[2:0]; inSign = sgn; inExp = e[9:0]; inMant = m[31:0];
    expQ.push_back(model(cls, sgn, e, m, tag));
    @(negedge clk);
    inValid = 1'b0;
    compareNow();
  endtask

  task automatic idle(int cls, bit sgn, int e, longint unsigned m);
    expect_t x;
    @(negedge clk);
    inValid = 1'b0; inClass = cls[2:0]; inSign = sgn; inExp = e[9:0]; inMant = m[31:0];
    x.v = 1'b0; x.r = '0; x.nx = 1'b0; x.nv = 1'b0; x.tag = "R8";
    expQ.push_back(x);
    @(negedge clk);
    compareNow();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    held.r = '0; held.nx = 1'b0; held.nv = 1'b0; held.v = 1'b0; held.tag = "";
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outResult !== 32'd0 || outInexact !== 1'b0 || outInvalid !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: got v=%0b r=%h nx=%0b nv=%0b, expected all 0",
               outValid, outResult, outInexact, outInvalid);
    end
    rstN = 1'b1;

    apply(0, 0, 5, 64'h8000_0000, "R1 zero positive");
    apply(0, 1, 40, 64'hFFFF_FFFF, "R1 zero negative");
    apply(1, 0, 0, 64'h8000_0000, "R3 one exact");
    apply(1, 0, 3, 64'hB000_0001, "R4 positive truncate");
    apply(1, 1, 3, 64'hB000_0001, "R3 negative truncate");
    apply(1, 0, 30, 64'hFFFF_FFFF, "R4 max positive inexact");
    apply(1, 0, -1, 64'h8000_0000, "R4 half to zero");
    apply(1, 1, -300, 64'hC000_0000, "R4 tiny negative");
    apply(1, 1, 31, 64'h8000_0000, "R5 negative extreme exact");
    apply(1, 0, 31, 64'h8000_0000, "R5 positive extreme overflow");
    apply(1, 0, 31, 64'hFFFF_FFFF, "R5 magnitude above limit");
    apply(1, 1, 31, 64'h8000_0001, "R5 negative beyond limit");
    apply(1, 0, 32, 64'h8000_0000, "R2 exponent 32");
    apply(1, 1, 200, 64'hA5A5_A5A5, "R2 large exponent negative");
    idle(1, 1, 200, 64'hA5A5_A5A5);
    apply(2, 0, 0, 64'h8000_0000, "R6 infinity positive");
    apply(3, 1, 0, 64'hC000_0000, "R6 quiet NaN negative");
    apply(4, 0, 0, 64'hA000_0000, "R6 signalling NaN positive");
    apply(6, 1, 0, 64'h8000_0000, "R6 unused code");
    apply(1, 0, 31, 64'h8000_0000, "R7 overflow clears inexact");
    idle(0, 0, 0, 0);
    idle(1, 0, 3, 64'hFFFF_FFFF);

    // exponent sweep with mixed patterns
    for (int e = -3; e <= 34; e++) begin
      apply(1, e[0], e, 64'hC3A5_0F01 ^ (64'(e) << 7), "R3 sweep");
    end

    // back-to-back operands: each due one clock after its own input (R8)
    @(negedge clk);
    inValid = 1'b1; inClass = 3'd1; inSign = 1'b1; inExp = 10'd15; inMant = 32'hFFFF_0000;
    expQ.push_back(model(1, 1, 15, 64'hFFFF_0000, "R8 back-to-back first"));
    @(negedge clk);
    compareNow();
    inClass = 3'd1; inSign = 1'b0; inExp = 10'd7; inMant = 32'h8100_0000;
    expQ.push_back(model(1, 0, 7, 64'h8100_0000, "R8 back-to-back second"));
    @(negedge clk);
    inValid = 1'b0;
    compareNow();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule